// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block decides, every clock cycle, whether a small 8-bit processor core takes an interrupt. It holds the global enable flag and the in-service flag of the status word. It also holds a per-source mask bit and a per-source level bit. From these and the incoming request lines it produces a one-cycle accept strobe, the index of the winning source, and the flag values that follow acceptance.

Maskable sources come in two levels, high and low. While a high-level handler is running, the in-service flag is low and low-level sources are held off. A separate non-maskable line is taken on its rising edge, regardless of any flag.

The core's sequencer drives the enable/disable operations and reloads both flags when a handler returns. It writes the mask and level bits through a single configuration port and starts vector fetch when the strobe fires. Stacking, vector fetch and the pipeline stay outside this block.

Top module: `irq_accept_gate`

## Requirements
- R1: While the enable flag `ie` is 0, no maskable source is accepted. A non-maskable edge is still accepted.
- R2: While `ie` is 1, maskable source i is eligible exactly when `irq_req[i]` is 1, its mask bit is 0, and either `isp` is 1 or its level bit is 1. A level bit of 1 means high level.
- R3: A source whose mask bit is 1 is never accepted, at either level.
- R4: `op_di` clears `ie` and `op_ei` sets it. When both are asserted in one cycle, `op_di` wins.
- R5: While `isp` is 0, only sources with level bit 1 can be accepted.
- R6: Accepting a maskable source clears `ie`. It sets `isp` to the inverse of that source's level bit, so a high-level source gives 0 and a low-level source gives 1.
- R7: Among eligible sources, any high-level source beats any low-level source. Within one level, the lowest index wins.
- R8: A rising edge on `nmi_req` is accepted with `vec_idx` equal to N (8 by default), ahead of all maskable sources. It clears `ie` and leaves `isp` unchanged. A level held high is not accepted again.
- R9: After reset, `ie` is 0, `isp` is 1, all mask bits are 1, all level bits are 0 and `accept` is 0.
- R10: The decision made from the inputs in one cycle appears on `accept` and `vec_idx` after the next rising clock edge. `accept` is high for exactly that one cycle, and `vec_idx` is 0 whenever `accept` is 0.
- R11: A `cfg_wr` takes effect for decisions from the following cycle. `flag_load` writes both flags at once and overrides `op_di` and `op_ei`. An acceptance in the same cycle overrides `flag_load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N | Maskable request lines, index 0 first |
| nmi_req | input | 1 | Non-maskable request, taken on rising edge |
| op_ei | input | 1 | Enable-interrupts operation |
| op_di | input | 1 | Disable-interrupts operation |
| flag_load | input | 1 | Load both flags, as on handler return |
| flag_ie | input | 1 | Enable value for `flag_load` |
| flag_isp | input | 1 | In-service value for `flag_load` |
| cfg_wr | input | 1 | Write mask and level bits |
| cfg_mask | input | N | Mask bits to write, 1 blocks the source |
| cfg_prio | input | N | Level bits to write, 1 means high level |
| accept | output | 1 | One-cycle accept strobe |
| vec_idx | output | $clog2(N+1) | Winning source, N for non-maskable |
| ie | output | 1 | Global enable flag |
| isp | output | 1 | In-service flag, 0 while a high-level handler runs |
| mask_o | output | N | Current mask bits |
| prio_o | output | N | Current level bits |

## Verification
Directed patterns come first.
- A full request word with `ie` clear, then with every mask bit set, shows that gating refuses requests when it should.
- A request word that mixes high-level and low-level sources separates level precedence from index precedence.
- The same low-level requests with `isp` at 0 and then at 1 isolate the in-service blocking.
- A non-maskable edge arrives together with maskable requests and is then held high. This shows precedence, flag independence and edge detection.
- Same-cycle collisions of `op_ei`/`op_di`, `flag_load`/accept and a mask write against a pending request pin down update order.

A long run of random request words, masks, levels and control pulses then compares every cycle against a reference model.

// File: rtl/irq_accept_gate_pkg.sv
package irq_accept_gate_pkg;

    // Outcome of one acceptance decision
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_NMI  = 2'd1,
        PICK_HIGH = 2'd2,
        PICK_LOW  = 2'd3
    } pick_e;

    // Index into the per-level encoder array
    localparam int unsigned LVL_HIGH = 0;
    localparam int unsigned LVL_LOW  = 1;
    localparam int unsigned NUM_LVL  = 2;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] mask_in,
    input  logic [N-1:0] prio_in,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] prio_q
);

    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] prio;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.mask = mask_in;
            cfg_d.prio = prio_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask <= '1;
            cfg_q.prio <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_q = cfg_q.mask;
    assign prio_q = cfg_q.prio;

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top down so the lowest set index is the last one written
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
    import irq_accept_gate_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned VW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_req,
    input  logic          nmi_req,
    input  logic          op_ei,
    input  logic          op_di,
    input  logic          flag_load,
    input  logic          flag_ie,
    input  logic          flag_isp,
    input  logic          cfg_wr,
    input  logic [N-1:0]  cfg_mask,
    input  logic [N-1:0]  cfg_prio,
    output logic          accept,
    output logic [VW-1:0] vec_idx,
    output logic          ie,
    output logic          isp,
    output logic [N-1:0]  mask_o,
    output logic [N-1:0]  prio_o
);

    localparam int unsigned SW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic          ie;
        logic          isp;
        logic          nmi_seen;
        logic          accept;
        logic [VW-1:0] vec;
    } gate_t;

    gate_t st_d, st_q;

    logic [N-1:0]  mask_q, prio_q;
    logic [N-1:0]  elig;
    logic          nmi_edge;
    logic [N-1:0]  lvl_vec   [NUM_LVL];
    logic          lvl_found [NUM_LVL];
    logic [SW-1:0] lvl_idx   [NUM_LVL];
    pick_e         pick;

    irq_cfg_regs #(.N(N)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .mask_in (cfg_mask),
        .prio_in (cfg_prio),
        .mask_q  (mask_q),
        .prio_q  (prio_q)
    );

    // Eligibility: enable, mask clear, and in-service gating of low sources
    always_comb begin
        elig = irq_req & ~mask_q & {N{st_q.ie}} & (st_q.isp ? {N{1'b1}} : prio_q);
        lvl_vec[LVL_HIGH] = elig & prio_q;
        lvl_vec[LVL_LOW]  = elig & ~prio_q;
        nmi_edge = nmi_req & ~st_q.nmi_seen;
    end

    // One encoder per priority level
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        irq_first_set #(.N(N), .IW(SW)) u_enc (
            .vec   (lvl_vec[g]),
            .found (lvl_found[g]),
            .idx   (lvl_idx[g])
        );
    end

    always_comb begin
        if (nmi_edge)                 pick = PICK_NMI;
        else if (lvl_found[LVL_HIGH]) pick = PICK_HIGH;
        else if (lvl_found[LVL_LOW])  pick = PICK_LOW;
        else                          pick = PICK_NONE;
    end

    always_comb begin
        st_d          = st_q;
        st_d.nmi_seen = nmi_req;
        st_d.accept   = 1'b0;
        st_d.vec      = '0;
        unique case (pick)
            PICK_NMI: begin
                st_d.accept = 1'b1;
                st_d.vec    = VW'(N);
                st_d.ie     = 1'b0;
            end
            PICK_HIGH: begin
                st_d.accept = 1'b1;
                st_d.vec    = VW'(lvl_idx[LVL_HIGH]);
                st_d.ie     = 1'b0;
                st_d.isp    = 1'b0;
            end
            PICK_LOW: begin
                st_d.accept = 1'b1;
                st_d.vec    = VW'(lvl_idx[LVL_LOW]);
                st_d.ie     = 1'b0;
                st_d.isp    = 1'b1;
            end
            default: begin
                if (flag_load) begin
                    st_d.ie  = flag_ie;
                    st_d.isp = flag_isp;
                end else if (op_di) begin
                    st_d.ie = 1'b0;
                end else if (op_ei) begin
                    st_d.ie = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ie       <= 1'b0;
            st_q.isp      <= 1'b1;
            st_q.nmi_seen <= 1'b0;
            st_q.accept   <= 1'b0;
            st_q.vec      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept  = st_q.accept;
    assign vec_idx = st_q.vec;
    assign ie      = st_q.ie;
    assign isp     = st_q.isp;
    assign mask_o  = mask_q;
    assign prio_o  = prio_q;

endmodule

// File: rtl/irq_accept_gate_chk.sv
module irq_accept_gate_chk #(
    parameter int unsigned N  = 8,
    parameter int unsigned VW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nmi_req,
    input logic          accept,
    input logic [VW-1:0] vec_idx,
    input logic          ie,
    input logic          isp,
    input logic [N-1:0]  mask_o,
    input logic [N-1:0]  prio_o
);

    localparam int unsigned SW = (N > 1) ? $clog2(N) : 1;

    logic         p_ie, p_isp, p_nmi, pp_nmi;
    logic [N-1:0] p_mask, p_prio;
    logic         maskable, sel_mask, sel_prio;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_ie   <= 1'b0;
            p_isp  <= 1'b1;
            p_nmi  <= 1'b0;
            pp_nmi <= 1'b0;
            p_mask <= '1;
            p_prio <= '0;
        end else begin
            p_ie   <= ie;
            p_isp  <= isp;
            p_nmi  <= nmi_req;
            pp_nmi <= p_nmi;
            p_mask <= mask_o;
            p_prio <= prio_o;
        end
    end

    always_comb begin
        maskable = accept && (vec_idx < VW'(N));
        sel_mask = p_mask[vec_idx[SW-1:0]];
        sel_prio = p_prio[vec_idx[SW-1:0]];
    end

    assert_masked_needs_ie_R1: assert property (@(posedge clk) disable iff (!rst_n)
        maskable |-> p_ie);

    assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        maskable |-> !sel_mask);

    assert_insvc_blocks_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (maskable && !p_isp) |-> sel_prio);

    assert_accept_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        maskable |-> (!ie && (isp == !sel_prio)));

    assert_nmi_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vec_idx == VW'(N)) |-> (p_nmi && !pp_nmi && !ie));

    assert_vec_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (vec_idx == '0));

endmodule

bind irq_accept_gate irq_accept_gate_chk #(.N(N), .VW(VW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_req (nmi_req),
    .accept  (accept),
    .vec_idx (vec_idx),
    .ie      (ie),
    .isp     (isp),
    .mask_o  (mask_o),
    .prio_o  (prio_o)
);

// File: tb/test_irq_accept_gate.sv
`timescale 1ns/100ps
module test_irq_accept_gate;

    localparam int unsigned N  = 8;
    localparam int unsigned VW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          nmi_req = 1'b0;
    logic          op_ei = 1'b0, op_di = 1'b0;
    logic          flag_load = 1'b0, flag_ie = 1'b0, flag_isp = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [N-1:0]  cfg_mask = '0, cfg_prio = '0;
    logic          accept;
    logic [VW-1:0] vec_idx;
    logic          ie, isp;
    logic [N-1:0]  mask_o, prio_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    irq_accept_gate #(.N(N)) i_irq_accept_gate (.*);

    typedef struct {
        logic          acc;
        logic [VW-1:0] vec;
        logic          ie;
        logic          isp;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state
    logic         m_ie = 1'b0, m_isp = 1'b1, m_nmi = 1'b0;
    logic [N-1:0] m_mask = '1, m_prio = '0;

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic step(input logic [N-1:0] rq, input logic nmi, input logic ei, input logic di,
                        input logic ld, input logic ld_ie, input logic ld_isp,
                        input logic wr, input logic [N-1:0] wm, input logic [N-1:0] wp,
                        input string tag);
        exp_t e;
        logic [N-1:0] el;
        int hi, lo;
        @(negedge clk);
        irq_req = rq; nmi_req = nmi; op_ei = ei; op_di = di;
        flag_load = ld; flag_ie = ld_ie; flag_isp = ld_isp;
        cfg_wr = wr; cfg_mask = wm; cfg_prio = wp;
        el = rq & ~m_mask & {N{m_ie}} & (m_isp ? {N{1'b1}} : m_prio);
        hi = lowest(el & m_prio);
        lo = lowest(el & ~m_prio);
        e.tag = tag; e.acc = 1'b0; e.vec = '0;
        if (nmi && !m_nmi) begin
            e.acc = 1'b1; e.vec = VW'(N); m_ie = 1'b0;
        end else if (hi >= 0) begin
            e.acc = 1'b1; e.vec = VW'(hi); m_ie = 1'b0; m_isp = 1'b0;
        end else if (lo >= 0) begin
            e.acc = 1'b1; e.vec = VW'(lo); m_ie = 1'b0; m_isp = 1'b1;
        end else if (ld) begin
            m_ie = ld_ie; m_isp = ld_isp;
        end else if (di) m_ie = 1'b0;
        else if (ei) m_ie = 1'b1;
        m_nmi = nmi;
        if (wr) begin m_mask = wm; m_prio = wp; end
        e.ie = m_ie; e.isp = m_isp;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, tag);
    endtask

    // Monitor: compare one expected item per clock, just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (accept !== e.acc || vec_idx !== e.vec || ie !== e.ie || isp !== e.isp) begin
                    bad++;
                    $display("FAIL %s: acc/vec/ie/isp actual=%0b/%0d/%0b/%0b expected=%0b/%0d/%0b/%0b",
                             e.tag, accept, vec_idx, ie, isp, e.acc, e.vec, e.ie, e.isp);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (ie !== 1'b0 || isp !== 1'b1 || accept !== 1'b0 || mask_o !== '1 || prio_o !== '0) begin
            bad++;
            $display("FAIL R9 reset: ie/isp/acc/mask/prio actual=%0b/%0b/%0b/%h/%h expected=0/1/0/ff/00",
                     ie, isp, accept, mask_o, prio_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: enable clear refuses every maskable request (masks also open later)
        step('1, 0, 0, 0, 0, 0, 0, 0, '0, '0, "R1 ie=0 refuses");
        // R3: enable set, all masks set -> nothing
        step('0, 0, 1, 0, 0, 0, 0, 0, '0, '0, "R4 ei sets ie");
        step('1, 0, 0, 0, 0, 0, 0, 0, '0, '0, "R3 all masked");
        // R11: config write, same-cycle request still sees old masks
        step('1, 0, 0, 0, 0, 0, 0, 1, 8'h00, 8'h20, "R11 cfg write next cycle");
        // R7: high-level source 5 beats low sources 1,2
        step(8'h26, 0, 0, 0, 0, 0, 0, 0, '0, '0, "R7 high level wins");
        idle("R10 strobe one cycle");
        // R5: isp=0 blocks low sources
        step('0, 0, 1, 0, 0, 0, 0, 0, '0, '0, "R4 ei again");
        step(8'h06, 0, 0, 0, 0, 0, 0, 0, '0, '0, "R5 isp=0 blocks low");
        // R11: flag_load restores both flags
        step('0, 0, 1, 1, 1, 1, 1, 0, '0, '0, "R11 load beats di/ei");
        // R7/R2: lowest low index wins with isp=1
        step(8'h06, 0, 0, 0, 0, 0, 0, 0, '0, '0, "R7 lowest index");
        // R8: NMI with ie=0 and maskable pending
        step(8'h20, 1, 0, 0, 0, 0, 0, 0, '0, '0, "R8 nmi accepted");
        step(8'h20, 1, 1, 0, 0, 0, 0, 0, '0, '0, "R8 nmi held no repeat");
        step(8'h20, 1, 0, 0, 0, 0, 0, 0, '0, '0, "R8 nmi held high-level src");
        step('0, 0, 1, 1, 0, 0, 0, 0, '0, '0, "R4 di beats ei");
        // R3: mask only source 1, prio none
        step('0, 0, 1, 0, 1, 1, 1, 1, 8'h02, 8'h00, "R11 load flags and cfg");
        step(8'h0A, 0, 0, 0, 1, 1, 0, 0, '0, '0, "R3 masked src skipped, R11 accept beats load");
        // R8: NMI alongside high-level request while ie=1
        step('0, 0, 1, 0, 0, 0, 0, 1, 8'h00, 8'h01, "R4 ei");
        step(8'h01, 1, 0, 0, 0, 0, 0, 0, '0, '0, "R8 nmi precedence");
        idle("R10 idle after nmi");

        // Random traffic against the model
        for (int k = 0; k < 600; k++) begin
            logic [N-1:0] rq, wm, wp;
            logic nm, ei, di, ld, wr;
            rq = N'($urandom);
            wm = N'($urandom) & N'($urandom);
            wp = N'($urandom);
            nm = ($urandom % 8) == 0;
            ei = ($urandom % 2) == 0;
            di = ($urandom % 6) == 0;
            ld = ($urandom % 5) == 0;
            wr = ($urandom % 10) == 0;
            step(rq, nm, ei, di, ld, 1'($urandom), 1'($urandom), wr, wm, wp, "R2 random");
        end
        idle("R10 drain");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule